// File: doc/BRIEF.md
# Fixed-Point Scaled Timestamp Counter

This block produces a free-running 64-bit timestamp for consumers such as system timers, which read a shared count instead of counting a clock themselves. Internally it keeps an 88-bit accumulator treated as a fixed-point number with 64 integer bits and 24 fraction bits. The timestamp is the integer part. On each clock where counting is enabled, the accumulator grows by a programmable increment when scaling is on, or by exactly one integer unit when scaling is off. With a non-unit increment the timestamp can therefore run at a rate that is not a whole multiple of the input clock.

Software, through a bus decoder outside this block, can overwrite either 32-bit half of the timestamp while the other half keeps its live value. Any such write also discards the accumulated fraction. The scale increment sits in a 32-bit register loaded by a strobe. Its reset value is one integer unit, so the counter steps once per clock after reset even with scaling on.

Top module: `tsc_scaled_counter`

## Requirements
- R1: While `rst` is high on a rising edge, the accumulator is cleared, so `count` reads 0 afterwards. The scale register resets to 0x01000000, so with scaling on and no scale load, `count` then rises by exactly 1 per enabled clock.
- R2: On a clock where `cnt_en` is low and neither `wr_lo` nor `wr_hi` is high, `count` does not change.
- R3: On an enabled clock with `scale_en` low and no write strobe, `count` rises by exactly 1, whatever the scale register holds.
- R4: On an enabled clock with `scale_en` high and no write strobe, the scale register value (read as an unsigned number with 24 fraction bits) is added to the 88-bit accumulator. Starting from a fraction of zero and count C, after n such clocks `count` equals C + floor(n * scale / 2^24).
- R5: `wr_lo` puts `wr_data` into `count[31:0]`. `count[63:32]` keeps its current value, and the 24 fraction bits become zero.
- R6: `wr_hi` puts `wr_data` into `count[63:32]`. `count[31:0]` keeps its current value, and the 24 fraction bits become zero.
- R7: A write strobe takes priority over counting. On a clock with a write and `cnt_en` high, no increment is added.
- R8: `scale_wr` loads `scale_val` into the scale register on that clock edge. A tick on the same edge still uses the old value, and the new value applies from the following tick.
- R9: The accumulator wraps modulo 2^88, so `count` wraps from 0xFFFFFFFFFFFFFFFF to small values.
- R10: With `wr_lo` and `wr_hi` both high, `wr_data` goes into both halves of `count`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock; every rising edge is one tick |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counting enable |
| scale_en | input | 1 | Use the scale register as the increment instead of one unit |
| scale_wr | input | 1 | Load strobe for the scale register |
| scale_val | input | 32 | New scale increment, 8 integer and 24 fraction bits |
| wr_lo | input | 1 | Replace the low 32 bits of the count |
| wr_hi | input | 1 | Replace the high 32 bits of the count |
| wr_data | input | 32 | Data for a half-count write |
| count | output | 64 | Integer part of the accumulator |

## Verification
Two pairs of events can land on the same edge. A half-count write can coincide with a counting tick, and a scale load can coincide with a tick. The bench holds `cnt_en` high while it writes one half, then checks that the written half holds exactly the written value and the other half did not advance. It also checks that a later carry from the low half into the high half works. For the second pair, it loads a new scale on an enabled edge and checks that this step used the old increment and only the next step used the new one. It also leaves a half-unit fraction pending before a write, then checks that the next tick does not absorb it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    parameter int CNT_W   = 64;
    parameter int FRAC_W  = 24;
    parameter int SCALE_W = 32;
    parameter int ACC_W   = CNT_W + FRAC_W;
    parameter int HALF_W  = CNT_W / 2;

    typedef logic [ACC_W-1:0]   acc_t;
    typedef logic [CNT_W-1:0]   cnt_t;
    typedef logic [SCALE_W-1:0] scale_t;
    typedef logic [HALF_W-1:0]  half_t;

    typedef struct packed {
        logic hi;
        logic lo;
    } wr_sel_t;

    localparam acc_t   UNIT_INC  = acc_t'(1) << FRAC_W;
    localparam scale_t SCALE_RST = scale_t'(1) << FRAC_W;

    function automatic cnt_t merge_halves(input cnt_t cur, input half_t d,
                                          input wr_sel_t sel);
        cnt_t r;
        r = cur;
        if (sel.lo) r[HALF_W-1:0]     = d;
        if (sel.hi) r[CNT_W-1:HALF_W] = d;
        return r;
    endfunction

    function automatic acc_t widen_scale(input scale_t s);
        return {{(ACC_W-SCALE_W){1'b0}}, s};
    endfunction
endpackage

// File: rtl/tsc_scale_reg.sv
module tsc_scale_reg
    import tsc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  scale_t load_val,
    output scale_t scale_q
);
    always_ff @(posedge clk) begin
        if (rst)       scale_q <= SCALE_RST;
        else if (load) scale_q <= load_val;
    end
endmodule

// File: rtl/tsc_step_sel.sv
module tsc_step_sel
    import tsc_pkg::*;
(
    input  logic   scale_en,
    input  scale_t scale_q,
    output acc_t   inc
);
    always_comb begin
        if (scale_en) inc = widen_scale(scale_q);
        else          inc = UNIT_INC;
    end
endmodule

// File: rtl/tsc_accum.sv
module tsc_accum
    import tsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cnt_en,
    input  acc_t    inc,
    input  wr_sel_t wr,
    input  half_t   wr_data,
    output cnt_t    count
);
    acc_t acc_q;
    acc_t acc_n;
    logic any_wr;

    assign any_wr = wr.lo | wr.hi;
    assign count  = acc_q[ACC_W-1:FRAC_W];

    always_comb begin
        acc_n = acc_q;
        if (any_wr)
            acc_n = {merge_halves(acc_q[ACC_W-1:FRAC_W], wr_data, wr), {FRAC_W{1'b0}}};
        else if (cnt_en)
            acc_n = acc_q + inc;
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_n;
    end

    AST_FRAC_CLR: assert property (@(posedge clk) disable iff (rst)
        any_wr |=> (acc_q[FRAC_W-1:0] == '0)); // R5
endmodule

// File: rtl/tsc_scaled_counter.sv
module tsc_scaled_counter
    import tsc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cnt_en,
    input  logic                scale_en,
    input  logic                scale_wr,
    input  logic [SCALE_W-1:0]  scale_val,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wr_data,
    output logic [CNT_W-1:0]    count
);
    scale_t  scale_q;
    acc_t    inc;
    wr_sel_t wr;

    assign wr.lo = wr_lo;
    assign wr.hi = wr_hi;

    tsc_scale_reg u_scale (
        .clk      (clk),
        .rst      (rst),
        .load     (scale_wr),
        .load_val (scale_val),
        .scale_q  (scale_q)
    );

    tsc_step_sel u_step (
        .scale_en (scale_en),
        .scale_q  (scale_q),
        .inc      (inc)
    );

    tsc_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .inc     (inc),
        .wr      (wr),
        .wr_data (wr_data),
        .count   (count)
    );

    AST_RST_ZERO: assert property (@(posedge clk)
        rst |=> (count == '0)); // R1
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !wr_lo && !wr_hi) |=> $stable(count)); // R2
    AST_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !scale_en && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1)); // R3
    AST_SCALE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && scale_en && !wr_lo && !wr_hi)
        |=> ((count - $past(count)) <= (cnt_t'(1) << (SCALE_W - FRAC_W)))); // R4
    AST_WR_LO: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !wr_hi) |=> (count[HALF_W-1:0] == $past(wr_data)
                               && count[CNT_W-1:HALF_W] == $past(count[CNT_W-1:HALF_W]))); // R5
    AST_WR_HI: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && !wr_lo) |=> (count[CNT_W-1:HALF_W] == $past(wr_data)
                               && count[HALF_W-1:0] == $past(count[HALF_W-1:0]))); // R6
    AST_WR_BOTH: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && wr_lo) |=> (count == {$past(wr_data), $past(wr_data)})); // R10
endmodule

// File: tb/tsc_scaled_counter_tb.sv
module tsc_scaled_counter_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_en, scale_en, scale_wr, wr_lo, wr_hi;
    logic [31:0] scale_val, wr_data;
    logic [63:0] count;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    tsc_scaled_counter u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .scale_en(scale_en),
        .scale_wr(scale_wr), .scale_val(scale_val), .wr_lo(wr_lo),
        .wr_hi(wr_hi), .wr_data(wr_data), .count(count)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: count=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic idle();
        cnt_en = 0; scale_wr = 0; wr_lo = 0; wr_hi = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: count=%h expected=run complete", count);
        finish_run();
    end

    initial begin
        logic [63:0] hold_v, hi_v;
        logic [31:0] sweep [6];
        sweep[0] = 32'h0040_0000; sweep[1] = 32'h00C0_0000; sweep[2] = 32'h0180_0000;
        sweep[3] = 32'h0000_0001; sweep[4] = 32'hFFFF_FFFF; sweep[5] = 32'h0012_3456;

        rst = 1; idle(); scale_en = 0; scale_val = 0; wr_data = 0;
        cyc(); cyc();
        chk("R1 reset", count, 64'd0);
        rst = 0;

        // R1: reset scale value gives one count per tick with scaling on
        cnt_en = 1; scale_en = 1;
        for (int i = 1; i <= 10; i++) begin
            cyc(); chk("R1 reset scale", count, 64'(i));
        end

        // R2: hold
        cnt_en = 0; hold_v = count;
        for (int i = 0; i < 5; i++) begin
            cyc(); chk("R2 hold", count, hold_v);
        end

        // R3: unit step ignores the scale register
        scale_wr = 1; scale_val = 32'h0080_0000; cyc(); scale_wr = 0;
        scale_en = 0; cnt_en = 1;
        for (int i = 1; i <= 8; i++) begin
            cyc(); chk("R3 unit step", count, hold_v + 64'(i));
        end

        // R4 sweep; setup write of both halves also covers R10
        for (int k = 0; k < 6; k++) begin
            idle(); wr_lo = 1; wr_hi = 1; wr_data = 0;
            scale_wr = 1; scale_val = sweep[k];
            cyc();
            chk("R10 both halves zero", count, 64'd0);
            idle(); cnt_en = 1; scale_en = 1;
            for (int n = 1; n <= 40; n++) begin
                logic [87:0] prod;
                prod = 88'(n) * 88'(sweep[k]);
                cyc(); chk("R4 scaled sum", count, prod[87:24]);
            end
        end

        // R8: scale load on a counting edge uses the old increment
        idle(); wr_lo = 1; wr_hi = 1; wr_data = 0; scale_wr = 1; scale_val = 32'h0100_0000;
        cyc(); idle();
        cnt_en = 1; scale_en = 1; scale_wr = 1; scale_val = 32'h0300_0000;
        cyc(); chk("R8 old increment", count, 64'd1);
        scale_wr = 0;
        cyc(); chk("R8 new increment", count, 64'd4);

        // R10 with a non-zero pattern
        idle(); wr_lo = 1; wr_hi = 1; wr_data = 32'hA5A5_A5A5;
        cyc(); chk("R10 both halves", count, 64'hA5A5_A5A5_A5A5_A5A5);

        // R5 and R7: low write while counting; high half is kept
        idle(); wr_hi = 1; wr_data = 32'h1234_5678; cyc();
        idle(); wr_lo = 1; wr_data = 32'h9ABC_DEF0; cyc();
        chk("R5 load", count, 64'h1234_5678_9ABC_DEF0);
        idle(); cnt_en = 1; scale_en = 0; cyc(); cyc();
        hi_v = count;
        wr_lo = 1; wr_data = 32'hFFFF_FFFE;
        cyc(); chk("R7 write beats tick", count, {hi_v[63:32], 32'hFFFF_FFFE});
        wr_lo = 0;
        cyc(); chk("R5 next tick", count, {hi_v[63:32], 32'hFFFF_FFFF});
        cyc(); chk("R5 carry", count, {hi_v[63:32] + 32'd1, 32'h0});

        // R6: high write while counting; low half is kept, no tick
        hold_v = count;
        wr_hi = 1; wr_data = 32'hDEAD_BEEF;
        cyc(); chk("R6 high write", count, {32'hDEAD_BEEF, hold_v[31:0]});
        wr_hi = 0;
        cyc(); chk("R6 next tick", count, {32'hDEAD_BEEF, hold_v[31:0] + 32'd1});

        // R5: write clears the pending fraction
        idle(); wr_lo = 1; wr_hi = 1; wr_data = 0; scale_wr = 1; scale_val = 32'h0080_0000;
        cyc(); idle();
        cnt_en = 1; scale_en = 1;
        cyc(); chk("R5 half unit", count, 64'd0);
        wr_lo = 1; wr_data = 32'd5;
        cyc(); chk("R5 frac write", count, 64'd5);
        wr_lo = 0;
        cyc(); chk("R5 frac cleared", count, 64'd5);
        cyc(); chk("R5 frac resumes", count, 64'd6);

        // R9: wrap, unit and scaled
        idle(); wr_lo = 1; wr_hi = 1; wr_data = 32'hFFFF_FFFF; cyc();
        idle(); cnt_en = 1; scale_en = 0;
        cyc(); chk("R9 unit wrap", count, 64'd0);
        idle(); wr_lo = 1; wr_hi = 1; wr_data = 32'hFFFF_FFFF;
        scale_wr = 1; scale_val = 32'h0200_0000; cyc();
        idle(); cnt_en = 1; scale_en = 1;
        cyc(); chk("R9 scaled wrap", count, 64'd1);

        // R1 again: reset mid-run restores count and scale
        idle(); rst = 1; cyc(); rst = 0;
        chk("R1 re-reset", count, 64'd0);
        cnt_en = 1; scale_en = 1;
        cyc(); cyc(); chk("R1 scale after reset", count, 64'd2);

        finish_run();
    end
endmodule